// File: doc/BRIEF.md
# Addressed SPI Command Slave with CRC-Checked Reads and Poll Hand-Off

This block is the serial front end of one device on a bus that several stacked devices share. It runs in SPI mode 3: the clock idles high, input bits are taken on the rising clock edge, and output bits move on the falling edge. Bytes are eight bits, most significant bit first. The chip-select, clock and data pins are brought into the system clock domain and oversampled there. All framing and decoding run in that domain.

A transaction starts with an optional address prefix byte. The upper nibble of the prefix is `1000` and the lower nibble selects a device. When the prefix names another device, the block stays silent until chip select rises. When there is no prefix, the first byte is a broadcast command, and every device acts on it.

The command byte selects one of three actions:
- A write to a register group. The data is staged and only committed to an internal register file when chip select rises.
- A read of a register group. The group's bytes are followed by a CRC-8 check byte.
- A poll. SDO is handed to an external status level and SCK is ignored until chip select rises.

The rest of the chip reads the register file through a core-side port.

Top module: `spi_cmd_slave`

## Requirements
- R1: SDI is sampled on the rising edge of SCK while CSB is low, and each received byte is assembled most significant bit first.
- R2: During a read, SDO changes only after a falling SCK edge, never while SCK is high. The first data bit (bit 7) appears after the first falling edge that follows the command byte.
- R3: A first byte with upper nibble 4'b1000 is an address prefix. If its lower nibble equals `dev_addr`, the next byte is the command. If not, the whole transaction is ignored: no register changes and `spi_sdo_oe` stays 0.
- R4: A first byte whose upper nibble is not 4'b1000 is a broadcast command and is executed whatever `dev_addr` is.
- R5: Write opcode `OP_WR_BASE+g` (default 8'h10+g) stages data bytes for group g. Register index g*GRP_LEN+i receives the i-th data byte. Nothing changes before CSB rises. On the rise, the group is committed if at least GRP_LEN whole bytes arrived. Bytes beyond GRP_LEN are dropped.
- R6: If CSB rises after fewer than GRP_LEN data bytes, or in the middle of a byte, the write is aborted and no register changes.
- R7: Read opcode `OP_RD_BASE+g` (default 8'h20+g) returns the GRP_LEN bytes of group g in index order, MSB first, followed by one check byte.
- R8: The check byte is a CRC-8 with polynomial 8'h07 (x^8+x^2+x+1). It is computed MSB first, starting from seed `CRC_SEED` (default 8'hA5), over every data bit in the order read, with no final inversion.
- R9: After poll opcode `OP_POLL` (default 8'h30), `poll_sel` is 1 and `spi_sdo_oe` is 1. `spi_sdo` then equals `poll_level` delayed by one clock, regardless of SCK, until CSB rises.
- R10: An opcode that is none of the write, read or poll codes is ignored: `spi_sdo_oe` stays 0 and no register changes.
- R11: `spi_sdo_oe` is 0 while CSB is high, outside a read or poll, and after the check byte has been shifted out. `poll_sel` returns to 0 when CSB rises.
- R12: After reset, `spi_sdo_oe` and `poll_sel` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; SCK half period must be at least 6 cycles |
| rst | input | 1 | Synchronous active-high reset |
| dev_addr | input | 4 | Hardware address of this device |
| spi_csb | input | 1 | Chip select, active low |
| spi_sck | input | 1 | Serial clock, idles high |
| spi_sdi | input | 1 | Serial data in |
| spi_sdo | output | 1 | Serial data out value |
| spi_sdo_oe | output | 1 | Drive enable for SDO; released otherwise so the line floats high |
| poll_level | input | 1 | Status level to present on SDO during a poll |
| poll_sel | output | 1 | High while the block is in poll mode |
| core_raddr | input | RAW | Core-side register read index |
| core_rdata | output | 8 | Core-side register read data, one cycle latency |

## Verification
Two situations are the hardest to reach from the ports: a write that has been fully shifted in but not yet committed, and a write aborted at a non-byte boundary. The bench reaches the first by reading the core port while CSB is still held low after the last data bit. It reaches the second with a bit-level transfer task that stops after four bits. The address decode is swept over all sixteen prefix nibbles against a fixed device address. Reads are swept over many data patterns and both groups. Each check byte is recomputed arithmetically from the bytes the bench itself wrote.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

  localparam logic [3:0] ADDR_PREFIX = 4'b1000;
  localparam logic [7:0] CRC_POLY    = 8'h07;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FIRST,
    ST_CMD,
    ST_WR,
    ST_RD,
    ST_POLL,
    ST_IGN
  } slv_state_e;

  typedef enum logic [1:0] {
    CMD_NONE,
    CMD_WRITE,
    CMD_READ,
    CMD_POLL
  } cmd_kind_e;

  function automatic logic [7:0] crc8_shift(input logic [7:0] crc, input logic din);
    logic fb;
    fb = crc[7] ^ din;
    return {crc[6:0], 1'b0} ^ (fb ? CRC_POLY : 8'h00);
  endfunction

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int           W       = 3,
  parameter int           STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [W-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= RST_VAL;
        else     chain[s] <= din;
      end
    end else begin : g_tail
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= RST_VAL;
        else     chain[s] <= chain[s-1];
      end
    end
  end

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/crc8_serial.sv
module crc8_serial
  import spi_cmd_pkg::*;
#(
  parameter logic [7:0] SEED = 8'hA5
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       clr,
  input  logic       en,
  input  logic       din,
  output logic [7:0] crc
);

  always_ff @(posedge clk) begin
    if (rst)      crc <= SEED;
    else if (clr) crc <= SEED;
    else if (en)  crc <= crc8_shift(crc, din);
  end

  AST_CRC_RESEED: assert property (@(posedge clk) disable iff (rst)
    clr |=> (crc == SEED)); // R8

endmodule

// File: rtl/cmd_regfile.sv
module cmd_regfile #(
  parameter int DEPTH = 6,
  parameter int AW    = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] ra_addr,
  output logic [7:0]    ra_data,
  input  logic [AW-1:0] rb_addr,
  output logic [7:0]    rb_data
);

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    ra_data <= mem[ra_addr];
    rb_data <= mem[rb_addr];
  end

  AST_WADDR_RANGE: assert property (@(posedge clk) disable iff (rst)
    we |-> (int'(waddr) < DEPTH)); // R5

endmodule

// File: rtl/spi_cmd_slave.sv
module spi_cmd_slave
  import spi_cmd_pkg::*;
#(
  parameter int         NUM_GROUPS  = 2,
  parameter int         GRP_LEN     = 3,
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] OP_WR_BASE  = 8'h10,
  parameter logic [7:0] OP_RD_BASE  = 8'h20,
  parameter logic [7:0] OP_POLL     = 8'h30,
  parameter logic [7:0] CRC_SEED    = 8'hA5,
  // derived: register index width
  parameter int         RAW = (NUM_GROUPS * GRP_LEN > 1) ? $clog2(NUM_GROUPS * GRP_LEN) : 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [3:0]     dev_addr,
  input  logic           spi_csb,
  input  logic           spi_sck,
  input  logic           spi_sdi,
  output logic           spi_sdo,
  output logic           spi_sdo_oe,
  input  logic           poll_level,
  output logic           poll_sel,
  input  logic [RAW-1:0] core_raddr,
  output logic [7:0]     core_rdata
);

  localparam int DEPTH = NUM_GROUPS * GRP_LEN;
  localparam int GW    = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1;
  localparam int IW    = $clog2(GRP_LEN + 2);

  // ---------------- pin synchronisation and edge detection
  logic [2:0] pins_s;
  logic       csb_s, sck_s, sdi_s, csb_d, sck_d;
  logic       sck_rise, sck_fall, csb_rise, csb_fall;

  spi_pin_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b110)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  ({spi_csb, spi_sck, spi_sdi}),
    .dout (pins_s)
  );

  assign csb_s = pins_s[2];
  assign sck_s = pins_s[1];
  assign sdi_s = pins_s[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      csb_d <= 1'b1;
      sck_d <= 1'b1;
    end else begin
      csb_d <= csb_s;
      sck_d <= sck_s;
    end
  end

  assign sck_rise = sck_s & ~sck_d;
  assign sck_fall = ~sck_s & sck_d;
  assign csb_rise = csb_s & ~csb_d;
  assign csb_fall = ~csb_s & csb_d;

  // ---------------- state
  slv_state_e      st_q;
  logic [6:0]      rx_sh;
  logic [2:0]      rx_bit;
  logic [GW-1:0]   grp_q;
  logic [IW-1:0]   wcnt;
  logic [IW-1:0]   tx_idx;
  logic [2:0]      tx_bit;
  logic            sdo_q, sdo_oe_q, poll_q;
  logic            commit_act;
  logic [IW-1:0]   commit_idx;
  logic [GW-1:0]   commit_grp;
  logic [7:0]      stage [GRP_LEN];
  logic [7:0]      stage_rd;

  // ---------------- receive path
  logic       rx_take, rx_done, cmd_slot, is_prefix, addr_match;
  logic [7:0] rx_byte;

  assign rx_take    = sck_rise && !csb_s &&
                      (st_q == ST_FIRST || st_q == ST_CMD || st_q == ST_WR);
  assign rx_byte    = {rx_sh, sdi_s};
  assign rx_done    = rx_take && (rx_bit == 3'd7);
  assign is_prefix  = (rx_byte[7:4] == ADDR_PREFIX);
  assign addr_match = (rx_byte[3:0] == dev_addr);
  assign cmd_slot   = (st_q == ST_CMD) || (st_q == ST_FIRST && !is_prefix);

  // ---------------- command decode
  cmd_kind_e     dec_kind;
  logic [GW-1:0] dec_grp;

  always_comb begin
    dec_kind = CMD_NONE;
    dec_grp  = '0;
    if (rx_byte == OP_POLL) begin
      dec_kind = CMD_POLL;
    end else if (int'(rx_byte) >= int'(OP_WR_BASE) &&
                 int'(rx_byte) <  int'(OP_WR_BASE) + NUM_GROUPS) begin
      dec_kind = CMD_WRITE;
      dec_grp  = GW'(rx_byte - OP_WR_BASE);
    end else if (int'(rx_byte) >= int'(OP_RD_BASE) &&
                 int'(rx_byte) <  int'(OP_RD_BASE) + NUM_GROUPS) begin
      dec_kind = CMD_READ;
      dec_grp  = GW'(rx_byte - OP_RD_BASE);
    end
  end

  // ---------------- write staging
  logic stage_we;
  assign stage_we = rx_done && (st_q == ST_WR) && (int'(wcnt) < GRP_LEN);

  for (genvar i = 0; i < GRP_LEN; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (stage_we && wcnt == IW'(i)) stage[i] <= rx_byte;
    end
  end

  always_comb begin
    stage_rd = 8'h00;
    for (int i = 0; i < GRP_LEN; i++) begin
      if (commit_idx == IW'(i)) stage_rd = stage[i];
    end
  end

  // ---------------- register file
  logic           ram_we;
  logic [RAW-1:0] ram_waddr, spi_raddr;
  logic [7:0]     rd_q;

  assign ram_we    = commit_act;
  assign ram_waddr = RAW'(int'(commit_grp) * GRP_LEN + int'(commit_idx));

  cmd_regfile #(.DEPTH(DEPTH), .AW(RAW)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .we      (ram_we),
    .waddr   (ram_waddr),
    .wdata   (stage_rd),
    .ra_addr (spi_raddr),
    .ra_data (rd_q),
    .rb_addr (core_raddr),
    .rb_data (core_rdata)
  );

  // ---------------- transmit path and check byte
  logic       tx_in_data, tx_val, crc_clr, crc_en;
  logic [7:0] crc_val;

  assign tx_in_data = int'(tx_idx) < GRP_LEN;
  assign tx_val     = tx_in_data ? rd_q[3'd7 - tx_bit] : crc_val[3'd7 - tx_bit];
  assign spi_raddr  = tx_in_data ? RAW'(int'(grp_q) * GRP_LEN + int'(tx_idx))
                                 : RAW'(int'(grp_q) * GRP_LEN);
  assign crc_clr    = rx_done && cmd_slot && (dec_kind == CMD_READ);
  assign crc_en     = (st_q == ST_RD) && sck_fall && !csb_s && tx_in_data;

  crc8_serial #(.SEED(CRC_SEED)) u_crc (
    .clk (clk),
    .rst (rst),
    .clr (crc_clr),
    .en  (crc_en),
    .din (tx_val),
    .crc (crc_val)
  );

  // ---------------- main sequencer
  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_IDLE;
      rx_sh      <= '0;
      rx_bit     <= '0;
      grp_q      <= '0;
      wcnt       <= '0;
      tx_idx     <= '0;
      tx_bit     <= '0;
      sdo_q      <= 1'b1;
      sdo_oe_q   <= 1'b0;
      poll_q     <= 1'b0;
      commit_act <= 1'b0;
      commit_idx <= '0;
      commit_grp <= '0;
    end else begin
      if (commit_act) begin
        if (int'(commit_idx) == GRP_LEN - 1) commit_act <= 1'b0;
        else                                 commit_idx <= commit_idx + 1'b1;
      end

      if (csb_rise) begin
        st_q     <= ST_IDLE;
        sdo_oe_q <= 1'b0;
        poll_q   <= 1'b0;
        if (st_q == ST_WR && int'(wcnt) == GRP_LEN && rx_bit == 3'd0) begin
          commit_act <= 1'b1;
          commit_idx <= '0;
          commit_grp <= grp_q;
        end
      end else if (csb_fall) begin
        st_q   <= ST_FIRST;
        rx_bit <= '0;
        wcnt   <= '0;
      end else begin
        if (rx_take) begin
          rx_sh  <= rx_byte[6:0];
          rx_bit <= rx_bit + 3'd1;
        end
        if (stage_we) wcnt <= wcnt + 1'b1;

        if (rx_done && st_q == ST_FIRST && is_prefix) begin
          st_q <= addr_match ? ST_CMD : ST_IGN;
        end else if (rx_done && cmd_slot) begin
          case (dec_kind)
            CMD_WRITE: begin
              st_q  <= ST_WR;
              grp_q <= dec_grp;
              wcnt  <= '0;
            end
            CMD_READ: begin
              st_q   <= ST_RD;
              grp_q  <= dec_grp;
              tx_idx <= '0;
              tx_bit <= '0;
            end
            CMD_POLL: begin
              st_q     <= ST_POLL;
              poll_q   <= 1'b1;
              sdo_oe_q <= 1'b1;
              sdo_q    <= poll_level;
            end
            default: st_q <= ST_IGN;
          endcase
        end

        if (st_q == ST_RD && sck_fall) begin
          if (int'(tx_idx) <= GRP_LEN) begin
            sdo_q    <= tx_val;
            sdo_oe_q <= 1'b1;
            tx_bit   <= tx_bit + 3'd1;
            if (tx_bit == 3'd7) tx_idx <= tx_idx + 1'b1;
          end else begin
            sdo_oe_q <= 1'b0;
          end
        end

        if (st_q == ST_POLL) sdo_q <= poll_level;
      end
    end
  end

  assign spi_sdo    = sdo_q;
  assign spi_sdo_oe = sdo_oe_q;
  assign poll_sel   = poll_q;

  // ---------------- assertions
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_IDLE) |-> (!spi_sdo_oe && !poll_sel)); // R11

  AST_IGN_QUIET: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_IGN) |-> !spi_sdo_oe); // R10

  AST_POLL_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_POLL) |-> (spi_sdo == $past(poll_level) && spi_sdo_oe)); // R9

  AST_SDO_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_RD && $past(st_q) == ST_RD && spi_sdo != $past(spi_sdo))
      |-> $past(sck_fall)); // R2

  AST_COMMIT_IDLE: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> (st_q == ST_IDLE || st_q == ST_FIRST)); // R5

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    int'(wcnt) <= GRP_LEN); // R5

  AST_CRC_HOLD: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_RD && $past(st_q) == ST_RD && int'($past(tx_idx)) >= GRP_LEN)
      |-> $stable(crc_val)); // R8

endmodule

// File: tb/test_spi_cmd_slave.sv
module test_spi_cmd_slave;

  localparam int         NG    = 2;
  localparam int         GL    = 3;
  localparam int         RAW   = 3;
  localparam int         HALF  = 8;
  localparam int         GAP   = 24;
  localparam logic [7:0] OPW   = 8'h10;
  localparam logic [7:0] OPR   = 8'h20;
  localparam logic [7:0] OPP   = 8'h30;
  localparam logic [7:0] SEED  = 8'hA5;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [3:0]     dev_addr = 4'h5;
  logic           spi_csb = 1'b1;
  logic           spi_sck = 1'b1;
  logic           spi_sdi = 1'b0;
  logic           spi_sdo, spi_sdo_oe;
  logic           poll_level = 1'b1;
  logic           poll_sel;
  logic [RAW-1:0] core_raddr = '0;
  logic [7:0]     core_rdata;

  int n_tests = 0;
  int n_fail  = 0;
  int oe_cycles = 0;
  int sdo_bad = 0;
  logic prev_sdo = 1'b1, prev_oe = 1'b0;

  logic [7:0] model [NG*GL];
  logic [7:0] rbuf  [GL+1];

  always #10 clk = ~clk;

  spi_cmd_slave i_spi_cmd_slave (
    .clk(clk), .rst(rst), .dev_addr(dev_addr),
    .spi_csb(spi_csb), .spi_sck(spi_sck), .spi_sdi(spi_sdi),
    .spi_sdo(spi_sdo), .spi_sdo_oe(spi_sdo_oe),
    .poll_level(poll_level), .poll_sel(poll_sel),
    .core_raddr(core_raddr), .core_rdata(core_rdata)
  );

  always @(negedge clk) begin
    if (spi_sdo_oe) oe_cycles++;
    if (spi_sdo_oe && prev_oe && !poll_sel && spi_sdo != prev_sdo && spi_sck) sdo_bad++;
    prev_sdo = spi_sdo;
    prev_oe  = spi_sdo_oe;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int k, input int i);
    return 8'((k * 37 + i * 91 + 19) & 255);
  endfunction

  function automatic logic [7:0] crc_ref(input int g);
    logic [7:0] c;
    logic fb;
    c = SEED;
    for (int b = 0; b < GL; b++) begin
      for (int i = 7; i >= 0; i--) begin
        fb = c[7] ^ model[g*GL+b][i];
        c  = {c[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
      end
    end
    return c;
  endfunction

  task automatic spi_xfer(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
    rx = 8'h00;
    for (int i = 7; i >= 8 - nbits; i--) begin
      spi_sck = 1'b0;
      spi_sdi = tx[i];
      repeat (HALF) @(negedge clk);
      rx[i] = spi_sdo_oe ? spi_sdo : 1'b1;
      spi_sck = 1'b1;
      repeat (HALF) @(negedge clk);
    end
  endtask

  task automatic cs_low();
    @(negedge clk);
    spi_csb = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic cs_high();
    spi_csb = 1'b1;
    repeat (GAP) @(negedge clk);
  endtask

  task automatic spi_write(input bit addressed, input logic [3:0] pfx, input int g,
                           input int k, input int nbytes);
    logic [7:0] d;
    cs_low();
    if (addressed) spi_xfer({4'b1000, pfx}, 8, d);
    spi_xfer(OPW + 8'(g), 8, d);
    for (int i = 0; i < nbytes; i++) spi_xfer(pat(k, i), 8, d);
    cs_high();
  endtask

  task automatic spi_read(input bit addressed, input logic [3:0] pfx, input int g);
    logic [7:0] d;
    cs_low();
    if (addressed) spi_xfer({4'b1000, pfx}, 8, d);
    spi_xfer(OPR + 8'(g), 8, d);
    for (int i = 0; i <= GL; i++) spi_xfer(8'h00, 8, rbuf[i]);
    cs_high();
  endtask

  task automatic peek(input int a, output logic [7:0] v);
    core_raddr = RAW'(a);
    repeat (2) @(negedge clk);
    v = core_rdata;
  endtask

  task automatic check_group(input string req, input int g);
    logic [7:0] v;
    for (int i = 0; i < GL; i++) begin
      peek(g*GL+i, v);
      chk(req, {24'h0, v}, {24'h0, model[g*GL+i]});
    end
  endtask

  task automatic set_model(input int g, input int k);
    for (int i = 0; i < GL; i++) model[g*GL+i] = pat(k, i);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int oe0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (5) @(negedge clk);

    // R12: reset state
    chk("R12 oe", {31'h0, spi_sdo_oe}, 32'h0);
    chk("R12 poll_sel", {31'h0, poll_sel}, 32'h0);

    // R4: broadcast writes set known contents regardless of address
    for (int g = 0; g < NG; g++) begin
      spi_write(1'b0, 4'h0, g, 50 + g, GL);
      set_model(g, 50 + g);
      check_group("R4 broadcast write", g);
    end

    // R3: sweep all prefix nibbles against dev_addr 5
    for (int p = 0; p < 16; p++) begin
      spi_write(1'b1, 4'(p), p % 2, 100 + p, GL);
      if (p == 5) set_model(p % 2, 100 + p);
      check_group("R3 prefix sweep", p % 2);
    end

    // R7/R8/R1/R2: read sweep over patterns, groups and both framings
    for (int k = 0; k < 6; k++) begin
      if (k >= 3) dev_addr = 4'hA;
      for (int g = 0; g < NG; g++) begin
        spi_write(1'b0, 4'h0, g, 200 + k*2 + g, GL);
        set_model(g, 200 + k*2 + g);
        spi_read(k % 2 == 0, dev_addr, g);
        for (int i = 0; i < GL; i++)
          chk("R7 R1 read data", {24'h0, rbuf[i]}, {24'h0, model[g*GL+i]});
        chk("R8 check byte", {24'h0, rbuf[GL]}, {24'h0, crc_ref(g)});
      end
    end
    dev_addr = 4'h5;

    // R3/R11: read with a foreign prefix never drives SDO
    oe0 = oe_cycles;
    spi_read(1'b1, 4'h6, 0);
    chk("R3 foreign read oe", oe_cycles - oe0, 0);

    // R5: no commit before CSB rises, commit after
    cs_low();
    spi_xfer(OPW, 8, d);
    for (int i = 0; i < GL; i++) spi_xfer(pat(300, i), 8, d);
    peek(0, d);
    chk("R5 before rise", {24'h0, d}, {24'h0, model[0]});
    cs_high();
    set_model(0, 300);
    check_group("R5 after rise", 0);

    // R5: extra bytes beyond the group are dropped
    spi_write(1'b0, 4'h0, 1, 310, GL + 1);
    set_model(1, 310);
    check_group("R5 extra bytes", 1);

    // R6: too few bytes aborts
    spi_write(1'b0, 4'h0, 0, 320, GL - 1);
    check_group("R6 short write", 0);

    // R6: rise in the middle of a byte aborts
    cs_low();
    spi_xfer(OPW + 8'd1, 8, d);
    for (int i = 0; i < GL; i++) spi_xfer(pat(330, i), 8, d);
    spi_xfer(8'hFF, 4, d);
    cs_high();
    check_group("R6 mid-byte abort", 1);

    // R10: unknown opcode, broadcast and addressed
    oe0 = oe_cycles;
    cs_low();
    spi_xfer(8'h55, 8, d);
    for (int i = 0; i < GL; i++) spi_xfer(pat(340, i), 8, d);
    cs_high();
    cs_low();
    spi_xfer({4'b1000, dev_addr}, 8, d);
    spi_xfer(8'h3F, 8, d);
    for (int i = 0; i < GL; i++) spi_xfer(pat(341, i), 8, d);
    cs_high();
    chk("R10 unknown oe", oe_cycles - oe0, 0);
    check_group("R10 unknown regs", 0);
    check_group("R10 unknown regs", 1);

    // R9: poll mode follows poll_level and ignores SCK
    for (int a = 0; a < 2; a++) begin
      cs_low();
      if (a == 1) spi_xfer({4'b1000, dev_addr}, 8, d);
      spi_xfer(OPP, 8, d);
      repeat (4) @(negedge clk);
      chk("R9 poll_sel", {31'h0, poll_sel}, 32'h1);
      chk("R9 oe", {31'h0, spi_sdo_oe}, 32'h1);
      poll_level = 1'b0;
      repeat (2) @(negedge clk);
      chk("R9 level low", {31'h0, spi_sdo}, 32'h0);
      for (int t = 0; t < 4; t++) begin
        spi_sck = ~spi_sck;
        repeat (HALF) @(negedge clk);
        chk("R9 sck ignored", {31'h0, spi_sdo}, 32'h0);
      end
      spi_sck = 1'b1;
      poll_level = 1'b1;
      repeat (2) @(negedge clk);
      chk("R9 level high", {31'h0, spi_sdo}, 32'h1);
      cs_high();
      chk("R11 poll exit sel", {31'h0, poll_sel}, 32'h0);
      chk("R11 poll exit oe", {31'h0, spi_sdo_oe}, 32'h0);
    end

    // R11: released after the check byte even with CSB still low
    cs_low();
    spi_xfer(OPR, 8, d);
    for (int i = 0; i <= GL; i++) spi_xfer(8'h00, 8, d);
    spi_xfer(8'h00, 2, d);
    chk("R11 release after crc", {31'h0, spi_sdo_oe}, 32'h0);
    cs_high();

    // R2: SDO never moved while SCK was high during reads
    chk("R2 sdo timing", sdo_bad, 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule